// File: doc/BRIEF.md
# Contiguous Store Coalescing Buffer

This block gathers a store that reaches it as a series of narrow byte pieces and holds them as one growing access. When a flush is requested, it issues the gathered bytes downstream as a single write of up to sixteen bytes. Each piece carries a byte address, a size code, a 3-bit access type, an exclusive flag and right-aligned data. A piece joins the buffer only if it sits directly after the bytes already held and has the same attributes. Its bytes are stacked above the bytes already held.

A flush names the kind of write it expects, plain or exclusive. The buffered access type and exclusive flag then select the route of the write: plain, plain with release ordering, exclusive, or exclusive with ordering. Downstream answers each write with a completion pulse, and for an exclusive write that pulse carries a pass/fail bit. A piece or flush that breaks a merge or routing rule is dropped and reported on a registered error output with a code. Translation, ordering and exclusive monitoring are left to other blocks.

Top module: `stcoal_top`

## Requirements
- R1: After reset, pc_ready is 1 and wr_valid, fl_done and err_valid are 0.
- R2: A piece accepted into an empty buffer loads its address, access type (normal=0, stream=1, unprivileged=2, ordered=3, atomic=4), exclusive flag and size. The piece is 2^pc_size bytes and its data bits above that size are ignored. Buffer bytes above the piece are zero.
- R3: A piece whose address equals the buffered start address plus the buffered byte count, with equal type and exclusive flag, is appended above the held bytes. The byte count grows by the piece size.
- R4: A piece whose type or exclusive flag differs from a non-empty buffer is dropped with err_code 1.
- R5: A piece whose address is not contiguous with a non-empty buffer is dropped with err_code 2.
- R6: A piece with size code above 4, or one that would take the total past 16 bytes, is dropped with err_code 3. The buffer never holds more than 16 bytes.
- R7: A plain flush (fl_excl=0) of a non-exclusive buffer is routed by type. Normal, stream and unprivileged give wr_kind 0, and ordered gives wr_kind 1. Any other type is refused with err_code 4.
- R8: An exclusive flush (fl_excl=1) of an exclusive buffer is routed by type. Atomic gives wr_kind 2 and ordered gives wr_kind 3. Any other type is refused with err_code 4. fl_pass repeats downstream wr_pass for exclusive writes and is 1 for plain ones.
- R9: A flush whose fl_excl differs from the buffered exclusive flag is refused with err_code 5 and issues no write.
- R10: A flush while the buffer is empty is ignored: no write and no error.
- R11: While a write is outstanding, wr_valid, wr_addr, wr_size and wr_data hold until wr_done. pc_ready is 0 while a write is outstanding or fl_valid is high. The cycle after wr_done, fl_done pulses, wr_valid falls and the byte count is 0, so the next piece starts a new buffer.
- R12: err_valid is a one-cycle pulse in the cycle after the offending request, and a refused request leaves the buffer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_valid | input | 1 | Piece offered |
| pc_ready | output | 1 | Piece can be taken this cycle |
| pc_addr | input | ADDR_W | Piece byte address |
| pc_size | input | 3 | Piece size code, bytes = 2^code |
| pc_type | input | 3 | Piece access type |
| pc_excl | input | 1 | Piece exclusive flag |
| pc_data | input | 8*MAX_BYTES | Piece data, right aligned |
| fl_valid | input | 1 | Flush request |
| fl_excl | input | 1 | Flush kind: 1 exclusive, 0 plain |
| fl_done | output | 1 | Flush finished pulse |
| fl_pass | output | 1 | Flush outcome, valid with fl_done |
| wr_valid | output | 1 | Downstream write outstanding |
| wr_addr | output | ADDR_W | Write start address |
| wr_size | output | $clog2(MAX_BYTES+1) | Buffered byte count |
| wr_kind | output | 2 | Route: bit 1 exclusive, bit 0 ordered |
| wr_data | output | 8*MAX_BYTES | Write data, zero above byte count |
| wr_done | input | 1 | Downstream completion pulse |
| wr_pass | input | 1 | Downstream exclusive success, with wr_done |
| err_valid | output | 1 | Error pulse |
| err_code | output | 3 | Error cause, valid with err_valid |

## Verification
The assertions rely on downstream raising wr_done only while wr_valid is high, for a single cycle. They also rely on fl_valid and pc_valid never being offered in the same cycle while a write is outstanding, except in handshake probes. The directed stimulus is built to that contract. The bench's downstream model answers only after it has seen wr_valid, and it holds wr_done for exactly one edge. Every piece and flush is raised at a falling edge and withdrawn just after the following rising edge. Ordered sequences cover merges, each error code and both flush kinds. Reset is used to leave buffers that can never be flushed, such as a non-exclusive atomic buffer.

// File: rtl/stcoal_pkg.sv
package stcoal_pkg;

   typedef enum logic [2:0] {
      ACC_NORMAL  = 3'd0,
      ACC_STREAM  = 3'd1,
      ACC_UNPRIV  = 3'd2,
      ACC_ORDERED = 3'd3,
      ACC_ATOMIC  = 3'd4
   } acc_e;

   typedef enum logic [2:0] {
      ERR_NONE  = 3'd0,
      ERR_ATTR  = 3'd1,
      ERR_GAP   = 3'd2,
      ERR_SIZE  = 3'd3,
      ERR_FTYPE = 3'd4,
      ERR_FKIND = 3'd5
   } err_e;

   // write route: bit 1 = exclusive, bit 0 = ordered
   localparam logic [1:0] KIND_PLAIN      = 2'b00;
   localparam logic [1:0] KIND_RELEASE    = 2'b01;
   localparam logic [1:0] KIND_EXCL       = 2'b10;
   localparam logic [1:0] KIND_EXCL_ORDER = 2'b11;

endpackage

// File: rtl/stcoal_merge.sv
module stcoal_merge
   import stcoal_pkg::*;
#(
   parameter int ADDR_W    = 64,
   parameter int MAX_BYTES = 16,
   localparam int DW       = 8 * MAX_BYTES,
   localparam int SZW      = $clog2(MAX_BYTES + 1),
   localparam int IDXW     = $clog2(MAX_BYTES)
) (
   input  logic [SZW-1:0]    old_bytes,
   input  logic [DW-1:0]     old_data,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [2:0]        old_type,
   input  logic              old_excl,
   input  logic [2:0]        p_code,
   input  logic [2:0]        p_type,
   input  logic              p_excl,
   input  logic [ADDR_W-1:0] p_addr,
   input  logic [DW-1:0]     p_data,
   output logic [SZW-1:0]    new_bytes,
   output logic [DW-1:0]     new_data,
   output logic [2:0]        err
);

   logic [SZW-1:0] p_bytes;
   logic [SZW:0]   sum;

   always_comb begin
      if (p_code <= 3'(IDXW)) p_bytes = SZW'(1) << p_code;
      else                    p_bytes = '0;
   end

   assign sum       = {1'b0, old_bytes} + {1'b0, p_bytes};
   assign new_bytes = sum[SZW-1:0];

   always_comb begin
      if (p_bytes == '0)
         err = 3'(ERR_SIZE);
      else if (old_bytes != '0 && (old_type != p_type || old_excl != p_excl))
         err = 3'(ERR_ATTR);
      else if (old_bytes != '0 && p_addr != start_addr + ADDR_W'(old_bytes))
         err = 3'(ERR_GAP);
      else if (sum > (SZW+1)'(MAX_BYTES))
         err = 3'(ERR_SIZE);
      else
         err = 3'(ERR_NONE);
   end

   // one byte lane per buffer byte: keep, take from the piece, or zero
   for (genvar i = 0; i < MAX_BYTES; i++) begin : g_lane
      localparam logic [SZW-1:0] LANE = SZW'(i);
      logic [SZW-1:0] idx;
      assign idx = LANE - old_bytes;
      always_comb begin
         if (LANE < old_bytes)
            new_data[i*8 +: 8] = old_data[i*8 +: 8];
         else if (idx < p_bytes)
            new_data[i*8 +: 8] = p_data[{idx[IDXW-1:0], 3'b000} +: 8];
         else
            new_data[i*8 +: 8] = 8'h00;
      end
   end

endmodule

// File: rtl/stcoal_route.sv
module stcoal_route
   import stcoal_pkg::*;
(
   input  logic [2:0] b_type,
   input  logic       b_excl,
   input  logic       f_excl,
   output logic [2:0] err,
   output logic [1:0] kind
);

   always_comb begin
      kind = KIND_PLAIN;
      err  = 3'(ERR_NONE);
      if (b_excl != f_excl) begin
         err = 3'(ERR_FKIND);
      end else if (!b_excl) begin
         if (b_type == 3'(ACC_ORDERED))     kind = KIND_RELEASE;
         else if (b_type < 3'(ACC_ORDERED)) kind = KIND_PLAIN;
         else                               err  = 3'(ERR_FTYPE);
      end else begin
         if (b_type == 3'(ACC_ATOMIC))       kind = KIND_EXCL;
         else if (b_type == 3'(ACC_ORDERED)) kind = KIND_EXCL_ORDER;
         else                                err  = 3'(ERR_FTYPE);
      end
   end

endmodule

// File: rtl/stcoal_top.sv
module stcoal_top
   import stcoal_pkg::*;
#(
   parameter int ADDR_W    = 64,
   parameter int MAX_BYTES = 16,
   localparam int DW       = 8 * MAX_BYTES,
   localparam int SZW      = $clog2(MAX_BYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pc_valid,
   output logic              pc_ready,
   input  logic [ADDR_W-1:0] pc_addr,
   input  logic [2:0]        pc_size,
   input  logic [2:0]        pc_type,
   input  logic              pc_excl,
   input  logic [DW-1:0]     pc_data,
   input  logic              fl_valid,
   input  logic              fl_excl,
   output logic              fl_done,
   output logic              fl_pass,
   output logic              wr_valid,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [SZW-1:0]    wr_size,
   output logic [1:0]        wr_kind,
   output logic [DW-1:0]     wr_data,
   input  logic              wr_done,
   input  logic              wr_pass,
   output logic              err_valid,
   output logic [2:0]        err_code
);

   if (MAX_BYTES < 2 || MAX_BYTES > 128 || (MAX_BYTES & (MAX_BYTES - 1)) != 0) begin : g_bad_bytes
      $error("MAX_BYTES must be a power of two from 2 to 128");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("ADDR_W must be at least 8");
   end

   logic              busy;
   logic [SZW-1:0]    b_size;
   logic [ADDR_W-1:0] b_addr;
   logic [2:0]        b_type;
   logic              b_excl;
   logic [DW-1:0]     b_data;
   logic [1:0]        kind_q;
   logic              done_q, pass_q, errv_q;
   logic [2:0]        errc_q;

   logic [SZW-1:0] m_bytes;
   logic [DW-1:0]  m_data;
   logic [2:0]     m_err, r_err;
   logic [1:0]     r_kind;
   logic           pc_fire, fl_take;

   stcoal_merge #(.ADDR_W(ADDR_W), .MAX_BYTES(MAX_BYTES)) u_merge (
      .old_bytes (b_size),
      .old_data  (b_data),
      .start_addr(b_addr),
      .old_type  (b_type),
      .old_excl  (b_excl),
      .p_code    (pc_size),
      .p_type    (pc_type),
      .p_excl    (pc_excl),
      .p_addr    (pc_addr),
      .p_data    (pc_data),
      .new_bytes (m_bytes),
      .new_data  (m_data),
      .err       (m_err)
   );

   stcoal_route u_route (
      .b_type(b_type),
      .b_excl(b_excl),
      .f_excl(fl_excl),
      .err   (r_err),
      .kind  (r_kind)
   );

   assign pc_ready = !busy && !fl_valid;
   assign pc_fire  = pc_valid && pc_ready;
   assign fl_take  = fl_valid && !busy && (b_size != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         b_size <= '0;
         b_addr <= '0;
         b_type <= '0;
         b_excl <= 1'b0;
         b_data <= '0;
         kind_q <= '0;
         done_q <= 1'b0;
         pass_q <= 1'b0;
         errv_q <= 1'b0;
         errc_q <= '0;
      end else begin
         done_q <= 1'b0;
         errv_q <= 1'b0;
         if (busy) begin
            if (wr_done) begin
               busy   <= 1'b0;
               b_size <= '0;
               b_data <= '0;
               done_q <= 1'b1;
               pass_q <= b_excl ? wr_pass : 1'b1;
            end
         end else if (fl_take) begin
            if (r_err == 3'(ERR_NONE)) begin
               busy   <= 1'b1;
               kind_q <= r_kind;
            end else begin
               errv_q <= 1'b1;
               errc_q <= r_err;
            end
         end else if (pc_fire) begin
            if (m_err == 3'(ERR_NONE)) begin
               b_size <= m_bytes;
               b_data <= m_data;
               if (b_size == '0) begin
                  b_addr <= pc_addr;
                  b_type <= pc_type;
                  b_excl <= pc_excl;
               end
            end else begin
               errv_q <= 1'b1;
               errc_q <= m_err;
            end
         end
      end
   end

   assign wr_valid  = busy;
   assign wr_addr   = b_addr;
   assign wr_size   = b_size;
   assign wr_kind   = kind_q;
   assign wr_data   = b_data;
   assign fl_done   = done_q;
   assign fl_pass   = pass_q;
   assign err_valid = errv_q;
   assign err_code  = errc_q;

   assert_hold_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !wr_done) |=> (wr_valid && $stable(wr_data) && $stable(wr_addr) && $stable(wr_size)));

   assert_done_after_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
      fl_done |-> $past(wr_valid && wr_done));

   assert_empty_after_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
      fl_done |-> (wr_size == '0 && !wr_valid));

   assert_no_piece_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> !pc_ready);

   assert_size_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_size <= SZW'(MAX_BYTES));

   assert_plain_route_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !wr_kind[1]) |-> (!b_excl && b_type <= 3'(ACC_ORDERED)));

   assert_excl_route_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_kind[1]) |-> (b_excl && (b_type == 3'(ACC_ATOMIC) || b_type == 3'(ACC_ORDERED))));

   assert_err_no_launch_R12: assert property (@(posedge clk) disable iff (!rst_n)
      err_valid |-> !$rose(wr_valid));

   assert_err_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
      err_valid |=> !err_valid || $past(pc_valid || fl_valid));

endmodule

// File: tb/stcoal_top_tb.sv
`timescale 1ns/1ps
module stcoal_top_tb;

   localparam int ADDR_W = 64;
   localparam int MB     = 16;
   localparam int DW     = 8 * MB;
   localparam int SZW    = $clog2(MB + 1);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              pc_valid = 1'b0;
   logic              pc_ready;
   logic [ADDR_W-1:0] pc_addr = '0;
   logic [2:0]        pc_size = '0;
   logic [2:0]        pc_type = '0;
   logic              pc_excl = 1'b0;
   logic [DW-1:0]     pc_data = '0;
   logic              fl_valid = 1'b0;
   logic              fl_excl = 1'b0;
   logic              fl_done, fl_pass;
   logic              wr_valid;
   logic [ADDR_W-1:0] wr_addr;
   logic [SZW-1:0]    wr_size;
   logic [1:0]        wr_kind;
   logic [DW-1:0]     wr_data;
   logic              wr_done = 1'b0;
   logic              wr_pass = 1'b0;
   logic              err_valid;
   logic [2:0]        err_code;

   int checks = 0;
   int fails  = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   stcoal_top #(.ADDR_W(ADDR_W), .MAX_BYTES(MB)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .pc_valid(pc_valid), .pc_ready(pc_ready), .pc_addr(pc_addr), .pc_size(pc_size),
      .pc_type(pc_type), .pc_excl(pc_excl), .pc_data(pc_data),
      .fl_valid(fl_valid), .fl_excl(fl_excl), .fl_done(fl_done), .fl_pass(fl_pass),
      .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_size(wr_size), .wr_kind(wr_kind),
      .wr_data(wr_data), .wr_done(wr_done), .wr_pass(wr_pass),
      .err_valid(err_valid), .err_code(err_code)
   );

   task automatic check(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      #1;
   endtask

   // offer one piece; exp_err = 0 means it must merge silently
   task automatic put(input logic [ADDR_W-1:0] a, input logic [2:0] code, input logic [2:0] ty,
                      input logic ex, input logic [DW-1:0] d, input logic [2:0] exp_err, input string req);
      @(negedge clk);
      pc_valid = 1'b1; pc_addr = a; pc_size = code; pc_type = ty; pc_excl = ex; pc_data = d;
      @(posedge clk);
      #1 pc_valid = 1'b0;
      check(err_valid == (exp_err != 3'd0), req, DW'(err_valid), DW'(exp_err != 3'd0));
      if (exp_err != 3'd0)
         check(err_code == exp_err, req, DW'(err_code), DW'(exp_err));
   endtask

   // flush that must be refused (code) or ignored (code 0)
   task automatic flush_refused(input logic ex, input logic [2:0] code, input string req);
      @(negedge clk);
      fl_valid = 1'b1; fl_excl = ex;
      @(posedge clk);
      #1 fl_valid = 1'b0;
      check(wr_valid == 1'b0, req, DW'(wr_valid), 0);
      check(err_valid == (code != 3'd0), req, DW'(err_valid), DW'(code != 3'd0));
      if (code != 3'd0) check(err_code == code, req, DW'(err_code), DW'(code));
      @(posedge clk);
      #1;
      check(err_valid == 1'b0 && wr_valid == 1'b0, {req, " pulse"}, DW'({err_valid, wr_valid}), 0);
   endtask

   // flush that must produce a write; downstream answers after `wait_cyc` cycles
   task automatic flush_write(input logic ex, input logic [ADDR_W-1:0] ea, input logic [SZW-1:0] es,
                              input logic [DW-1:0] ed, input logic [1:0] ek, input logic pass_in,
                              input logic exp_pass, input int wait_cyc, input string req);
      @(negedge clk);
      fl_valid = 1'b1; fl_excl = ex;
      #1 check(pc_ready == 1'b0, "R11 ready low with flush", DW'(pc_ready), 0);
      @(posedge clk);
      #1 fl_valid = 1'b0;
      check(wr_valid == 1'b1 && err_valid == 1'b0, req, DW'({wr_valid, err_valid}), 2);
      check(wr_addr == ea, req, DW'(wr_addr), DW'(ea));
      check(wr_size == es, req, DW'(wr_size), DW'(es));
      check(wr_data == ed, req, wr_data, ed);
      check(wr_kind == ek, req, DW'(wr_kind), DW'(ek));
      for (int k = 0; k < wait_cyc; k++) begin
         @(posedge clk);
         #1;
         check(wr_valid && wr_data == ed && wr_size == es && !pc_ready, "R11 hold", wr_data, ed);
      end
      @(negedge clk);
      wr_done = 1'b1; wr_pass = pass_in;
      @(posedge clk);
      #1 wr_done = 1'b0; wr_pass = 1'b0;
      check(fl_done == 1'b1 && wr_valid == 1'b0, "R11 done", DW'({fl_done, wr_valid}), 2);
      check(fl_pass == exp_pass, req, DW'(fl_pass), DW'(exp_pass));
      check(wr_size == '0 && pc_ready == 1'b1, "R11 empty after done", DW'(wr_size), 0);
      @(posedge clk);
      #1 check(fl_done == 1'b0, "R11 done pulse", DW'(fl_done), 0);
   endtask

   task automatic t_reset_R1();
      do_reset();
      check(pc_ready == 1'b1, "R1 ready", DW'(pc_ready), 1);
      check(!wr_valid && !fl_done && !err_valid, "R1 idle", DW'({wr_valid, fl_done, err_valid}), 0);
   endtask

   task automatic t_first_piece_R2();
      put(64'h1000, 3'd2, 3'd0, 1'b0, 128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_AABB_CCDD, 3'd0, "R2 load");
      flush_write(1'b0, 64'h1000, 5'd4, 128'hAABB_CCDD, 2'b00, 1'b0, 1'b1, 1, "R2 R7 normal flush");
   endtask

   task automatic t_merge_R3();
      put(64'h2000, 3'd1, 3'd3, 1'b0, 128'h1122, 3'd0, "R3 p0");
      put(64'h2002, 3'd0, 3'd3, 1'b0, 128'h33, 3'd0, "R3 p1");
      put(64'h2003, 3'd0, 3'd3, 1'b0, 128'h44, 3'd0, "R3 p2");
      put(64'h2004, 3'd2, 3'd3, 1'b0, 128'h5566_7788, 3'd0, "R3 p3");
      flush_write(1'b0, 64'h2000, 5'd8, 128'h5566_7788_4433_1122, 2'b01, 1'b0, 1'b1, 0, "R3 R7 ordered merge");
   endtask

   task automatic t_piece_errors();
      put(64'h3000, 3'd0, 3'd1, 1'b0, 128'h01, 3'd0, "R2 stream first");
      put(64'h3001, 3'd0, 3'd0, 1'b0, 128'hEE, 3'd1, "R4 type mismatch");
      put(64'h3001, 3'd0, 3'd1, 1'b1, 128'hEE, 3'd1, "R4 excl mismatch");
      put(64'h3005, 3'd0, 3'd1, 1'b0, 128'hEE, 3'd2, "R5 gap");
      put(64'h3001, 3'd5, 3'd1, 1'b0, 128'hEE, 3'd3, "R6 bad code");
      put(64'h3001, 3'd3, 3'd1, 1'b0, 128'hA1A2_A3A4_A5A6_A7A8, 3'd0, "R3 append 8");
      put(64'h3009, 3'd3, 3'd1, 1'b0, 128'hDEAD_BEEF_DEAD_BEEF, 3'd3, "R6 overflow");
      flush_write(1'b0, 64'h3000, 5'd9, 128'hA1A2_A3A4_A5A6_A7A8_01, 2'b00, 1'b0, 1'b1, 0,
                  "R12 R4 R5 R6 buffer unchanged");
   endtask

   task automatic t_exclusive_R8();
      put(64'h4000, 3'd3, 3'd4, 1'b1, 128'h0102_0304_0506_0708, 3'd0, "R8 atomic piece");
      flush_write(1'b1, 64'h4000, 5'd8, 128'h0102_0304_0506_0708, 2'b10, 1'b0, 1'b0, 2, "R8 atomic fail");
      put(64'h5000, 3'd4, 3'd3, 1'b1, 128'h0011_2233_4455_6677_8899_AABB_CCDD_EEFF, 3'd0, "R8 ordered piece");
      flush_write(1'b1, 64'h5000, 5'd16, 128'h0011_2233_4455_6677_8899_AABB_CCDD_EEFF, 2'b11, 1'b1, 1'b1, 0,
                  "R8 ordered pass");
   endtask

   task automatic t_handshake_R11();
      put(64'h6000, 3'd1, 3'd2, 1'b0, 128'hBEEF, 3'd0, "R11 unpriv piece");
      flush_write(1'b0, 64'h6000, 5'd2, 128'hBEEF, 2'b00, 1'b1, 1'b1, 3, "R11 R7 unpriv flush");
      put(64'h9000, 3'd0, 3'd0, 1'b0, 128'h5A, 3'd0, "R11 fresh start");
      flush_write(1'b0, 64'h9000, 5'd1, 128'h5A, 2'b00, 1'b0, 1'b1, 0, "R11 fresh flush");
   endtask

   task automatic t_flush_errors();
      do_reset();
      flush_refused(1'b0, 3'd0, "R10 empty plain");
      flush_refused(1'b1, 3'd0, "R10 empty excl");
      put(64'h7000, 3'd0, 3'd0, 1'b1, 128'h77, 3'd0, "R8 excl normal piece");
      flush_refused(1'b1, 3'd4, "R8 excl normal refused");
      flush_refused(1'b0, 3'd5, "R9 kind mismatch");
      do_reset();
      put(64'h8000, 3'd0, 3'd4, 1'b0, 128'h88, 3'd0, "R7 plain atomic piece");
      flush_refused(1'b0, 3'd4, "R7 plain atomic refused");
      flush_refused(1'b1, 3'd5, "R9 kind mismatch excl");
      do_reset();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      t_reset_R1();
      t_first_piece_R2();
      t_merge_R3();
      t_piece_errors();
      t_exclusive_R8();
      t_handshake_R11();
      t_flush_errors();
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule